// File: doc/BRIEF.md
# Clock Output Bank Stop Controller

This block passes one running source clock to several groups of clock outputs and can stop and restart some of those groups without ever cutting a pulse short. A two-bit stop code, driven asynchronously by board logic or a power manager, chooses which groups run. The code is brought into the source clock domain, decoded into a per-group stop mask, and each group's gate is changed only while the source clock is low.

A group that is told to stop finishes its current high phase and then stays low. A group that is told to run again starts on the next rising edge of the source clock, so its edges line up exactly with the groups that never stopped. Groups with an index of two or higher are never stopped and act as the phase reference for the others.

Top module: `outbank_gate`

## Requirements
- R1: The stop code passes through two synchronizer flops on the source rising edge. A code that changes between rising edges k and k+1 leaves the outputs at edges k+1 and k+2 as they were, and first shows on the outputs at edge k+3.
- R2: Code 2'b00 lets every group run: each output follows the source clock.
- R3: Code 2'b01 stops group 0 only. Group 1 and all higher groups keep running.
- R4: Code 2'b10 stops groups 0 and 1.
- R5: Code 2'b11 has the same effect as code 2'b10.
- R6: Groups with an index of 2 or more are never stopped by any code.
- R7: A stopped group's output stays low for every cycle that it is stopped.
- R8: A group that is restarted gives a full high phase that starts on the same source rising edge as the groups that kept running.
- R9: Every high and every low pulse on every output lasts at least half a source period.
- R10: While rst_n is low, all outputs are low. After rst_n rises, all groups that the code lets run give their first high phase at the first source rising edge after the next low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Running source clock that is passed to the outputs |
| rst_n | input | 1 | Asynchronous active-low reset. Assert it only while clk_src is low |
| stop_sel | input | 2 | Asynchronous stop code: 00 all run, 01 stop group 0, 10 or 11 stop groups 0 and 1 |
| grp_clk | output | NUM_GRP | Gated clock, one bit per output group |

## Verification
Two actions can take effect on the same rising edge: one group restarts while another stays stopped, for example when the code moves from 2'b11 to 2'b01, and the outputs come out of reset while the synchronized code is still taking effect. The bench provokes both. It steps through every code in several orders, and it also asserts reset in the middle of a run and releases it again. For each source edge it queues the expected output pattern, with the old mask for the two synchronizer cycles and the new mask after them, and it checks that pattern in the high phase. A separate monitor times every edge of every output, so a stop or restart that lands on the wrong phase shows up as a short pulse.

// File: rtl/outbank_pkg.sv
package outbank_pkg;

    typedef enum logic [1:0] {
        SEL_ALL_ON      = 2'b00,
        SEL_STOP_A      = 2'b01,
        SEL_STOP_AB     = 2'b10,
        SEL_STOP_AB_ALT = 2'b11
    } stop_sel_e;

    localparam int unsigned GRP_A   = 0;
    localparam int unsigned GRP_B   = 1;
    localparam int unsigned MIN_GRP = 2;

    // Returns {stop group B, stop group A} for a synchronized code.
    function automatic logic [1:0] stops_for(input stop_sel_e code);
        logic [1:0] s;
        case (code)
            SEL_ALL_ON:      s = 2'b00;
            SEL_STOP_A:      s = 2'b01;
            SEL_STOP_AB,
            SEL_STOP_AB_ALT: s = 2'b11;
            default:         s = 2'b11;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/outbank_sync.sv
module outbank_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.pipe[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.pipe[s] = sync_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q.pipe[LAST];

    generate
        if (STAGES == 2) begin : g_lat_chk
            AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n, 2) && $past(rst_n)) |-> (dout == $past(din, 2))); // R1
        end
    endgenerate

endmodule

// File: rtl/outbank_decode.sv
module outbank_decode
    import outbank_pkg::*;
#(
    parameter int unsigned NUM_GRP = 4
) (
    input  logic [1:0]         code,
    output logic [NUM_GRP-1:0] stop_mask
);

    logic [1:0] pair_stop;

    always_comb begin
        pair_stop = stops_for(stop_sel_e'(code));
    end

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
            if (g == GRP_A) begin : g_a
                assign stop_mask[g] = pair_stop[0];
            end else if (g == GRP_B) begin : g_b
                assign stop_mask[g] = pair_stop[1];
            end else begin : g_ref
                assign stop_mask[g] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/outbank_gate_cell.sv
module outbank_gate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    output logic gclk
);

    typedef struct packed {
        logic en;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d    = gate_q;
        gate_d.en = !stop;
    end

    // Updated on the falling edge, so the enable settles while clk is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gclk = clk & gate_q.en;

    AST_STOPPED_LOW: assert property (@(negedge clk) disable iff (!rst_n)
        $past(stop) |-> !gclk); // R7

    AST_RESTART_HIGH: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stop)) |-> gclk); // R8

endmodule

// File: rtl/outbank_gate.sv
module outbank_gate
    import outbank_pkg::*;
#(
    parameter int unsigned NUM_GRP     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_src,
    input  logic               rst_n,
    input  logic [1:0]         stop_sel,
    output logic [NUM_GRP-1:0] grp_clk
);

    localparam int unsigned CODE_W = 2;

    logic [CODE_W-1:0]  sel_s;
    logic [NUM_GRP-1:0] stop_mask;

    outbank_sync #(
        .WIDTH  (CODE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .din   (stop_sel),
        .dout  (sel_s)
    );

    outbank_decode #(
        .NUM_GRP (NUM_GRP)
    ) u_dec (
        .code      (sel_s),
        .stop_mask (stop_mask)
    );

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_cell
            outbank_gate_cell u_cell (
                .clk   (clk_src),
                .rst_n (rst_n),
                .stop  (stop_mask[g]),
                .gclk  (grp_clk[g])
            );
        end
    endgenerate

    AST_ALL_ON: assert property (@(negedge clk_src) disable iff (!rst_n)
        ($past(rst_n) && ($past(sel_s) == SEL_ALL_ON)) |-> (&grp_clk)); // R2

    AST_STOP_A_ONLY: assert property (@(negedge clk_src) disable iff (!rst_n)
        ($past(rst_n) && ($past(sel_s) == SEL_STOP_A)) |-> (!grp_clk[GRP_A] && grp_clk[GRP_B])); // R3

    AST_STOP_AB: assert property (@(negedge clk_src) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_s[1])) |-> (!grp_clk[GRP_A] && !grp_clk[GRP_B])); // R4 R5

    AST_RESET_LOW: assert property (@(negedge clk_src)
        !rst_n |-> (grp_clk == '0)); // R10

endmodule

// File: tb/tb_outbank_gate.sv
module tb_outbank_gate;

    localparam int      NG   = 4;
    localparam realtime HALF = 5.0;

    logic          clk_src = 1'b0;
    logic          rst_n   = 1'b1;
    logic [1:0]    stop_sel = 2'b00;
    logic [NG-1:0] grp_clk;

    always #5 clk_src = ~clk_src;

    outbank_gate #(.NUM_GRP(NG)) dut (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .stop_sel (stop_sel),
        .grp_clk  (grp_clk)
    );

    typedef struct {
        logic [NG-1:0] mask;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [NG-1:0] model_mask = '1;
    int            errors = 0;
    int            checks = 0;
    bit            done = 0;

    function automatic logic [NG-1:0] mask_for(input logic [1:0] c);
        logic [NG-1:0] m;
        m = '1;
        if (c != 2'b00) m[0] = 1'b0;
        if (c[1])       m[1] = 1'b0;
        return m;
    endfunction

    task automatic check_mask(input logic [NG-1:0] act, input logic [NG-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: grp_clk=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Called right at a rising edge; drives the code in the high phase.
    task automatic apply(input logic [1:0] c, input int n, input string tag);
        logic [NG-1:0] nm;
        #4;
        stop_sel = c;
        nm = mask_for(c);
        for (int i = 1; i <= n; i++) begin
            exp_t e;
            if (i <= 2) begin
                e.mask = model_mask;
                e.tag  = "R1";
            end else begin
                e.mask = nm;
                e.tag  = tag;
            end
            sb_q.push_back(e);
        end
        model_mask = nm;
        repeat (n) @(posedge clk_src);
    endtask

    task automatic release_rst(input int n);
        #4;
        rst_n = 1'b1;
        model_mask = mask_for(stop_sel);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.mask = model_mask;
            e.tag  = "R10";
            sb_q.push_back(e);
        end
        repeat (n) @(posedge clk_src);
    endtask

    // Scoreboard monitor: compares the high-phase output pattern.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk_src);
            #3;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check_mask(grp_clk, e.mask, e.tag);
            end
        end
    end

    // R9: time every edge on each output.
    generate
        for (genvar g = 0; g < NG; g++) begin : g_pw
            realtime last_t = 0.0;
            bit      have   = 0;
            always @(grp_clk[g]) begin
                realtime w;
                w = $realtime - last_t;
                if (have && rst_n) begin
                    checks++;
                    if (w < HALF - 0.01) begin
                        errors++;
                        $display("FAIL R9: group %0d pulse width %0.2f expected >= %0.2f at %0t",
                                 g, w, HALF, $time);
                    end
                end
                last_t = $realtime;
                have   = 1;
            end
        end
    endgenerate

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run not finished, actual running expected done");
            report();
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) begin
            @(posedge clk_src);
            #3;
            check_mask(grp_clk, '0, "R10");
        end
        @(posedge clk_src);
        release_rst(4);
        apply(2'b01, 6, "R3");
        apply(2'b00, 6, "R8");
        apply(2'b10, 6, "R4");
        apply(2'b11, 5, "R5");
        apply(2'b01, 6, "R8");
        apply(2'b11, 6, "R7");
        apply(2'b00, 5, "R2");
        // reset in the middle of a run, asserted in the low phase
        #7 rst_n = 1'b0;
        repeat (2) begin
            @(posedge clk_src);
            #3;
            check_mask(grp_clk, '0, "R10");
        end
        @(posedge clk_src);
        release_rst(3);
        apply(2'b10, 5, "R6");
        apply(2'b00, 4, "R8");
        @(posedge clk_src);
        #1;
        done = 1;
        report();
        $finish;
    end

endmodule